// File: doc/BRIEF.md
# Multi-queue interrupt moderation controller

This block sits in a receive path that spreads incoming packets over several processor queues. Each queue reports fresh descriptors with a one-cycle pulse on its bit of `work_in`. The block gathers these pulses and decides when the host is interrupted, so the host is not interrupted once per descriptor. A moderation timer starts at the first pending event, and a programmable event count can end the wait early.

There are two modes, chosen by `mode_per_q`. In single-interrupt mode (`mode_per_q` = 0) the block keeps a bit-vector of the queues that have work. When moderation expires it first asks an external bus engine to copy a snapshot of that vector to host memory. Only after that write is acknowledged does it pulse a single interrupt, which then stays masked until software re-enables it. In per-processor mode (`mode_per_q` = 1) every queue has its own moderation, its own one-cycle message interrupt and its own enable, so no shared completion tracking is needed. The single-interrupt mode stays available as the fallback. The mode bit may change only while every interrupt is masked.

Each control path is a state machine with the states MASKED, IDLE, MODERATE, WRITE (single path only) and FIRE:
- MASKED→MODERATE: on an enable when work is pending.
- MASKED→IDLE: on an enable with nothing pending.
- IDLE→MODERATE: on the first work.
- MODERATE→WRITE (single) or MODERATE→FIRE (per queue): on moderation expiry.
- WRITE→FIRE: on the write acknowledge.
- FIRE→MASKED: after one cycle.

Top module: `rxq_irq_moderator`

## Requirements
- R1: After reset every interrupt is masked and `vec_wr_req`, `irq_single` and `irq_q` are all 0. Work that arrives before any enable raises nothing.
- R2: In single mode a pulse on `work_in[i]` sets bit i of the vector, and `vec_wr_data` carries exactly the bits gathered before the request, with bit i meaning queue i.
- R3: With the count trigger off, `vec_wr_req` first reads 1 in the cycle that follows the clock edge D+2 edges after the first sampled work pulse. Here D is `mod_delay`, and the sampling edge is counted as the first edge.
- R4: With `mod_thresh` = N > 0 and work sampled on consecutive edges, the request follows edge N+1 when that is earlier than the timer. `mod_thresh` = 0 turns the count trigger off.
- R5: `vec_wr_req` stays high with stable `vec_wr_data` until `vec_wr_done` is sampled. `irq_single` is high for exactly the one cycle after that edge.
- R6: After `irq_single` fires, no further request or interrupt occurs until `sw_en_single` is pulsed, even if work arrives.
- R7: The vector is snapshotted and cleared when the request is issued. Work arriving afterwards does not alter `vec_wr_data`; it appears in the next write.
- R8: An enable while work is pending restarts moderation at once: the request follows edge D+2, counted from the enable edge.
- R9: In per-queue mode, work on queue i yields a one-cycle `irq_q[i]` after the same moderation timing as R3. It produces no vector write and no `irq_single`.
- R10: In per-queue mode each `irq_q[i]` masks itself after firing and is re-enabled only by `sw_en_q[i]`. Enabling one queue leaves the others masked, and work pending on a masked queue fires D+2 edges after its enable.
- R11: `mode_per_q` = 0 selects single mode and 1 selects per-queue mode. Enables and work meant for the inactive mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_per_q | input | 1 | 0 single-interrupt mode, 1 per-queue mode |
| mod_delay | input | TIMER_W | Moderation delay D in cycles |
| mod_thresh | input | CNT_W | Event count trigger, 0 = off |
| work_in | input | NQ | Per-queue new-descriptor pulses |
| sw_en_single | input | 1 | Software re-enable of the single interrupt |
| sw_en_q | input | NQ | Software re-enable per queue interrupt |
| vec_wr_done | input | 1 | Bus engine finished the vector write |
| vec_wr_req | output | 1 | Request to write the vector to host memory |
| vec_wr_data | output | NQ | Vector snapshot to be written |
| irq_single | output | 1 | Single interrupt pulse |
| irq_q | output | NQ | Per-queue interrupt pulses |

## Verification
A state machine stuck in the wrong state shows at the ports within one moderation window. An interrupt either fails to appear D+2 edges after work or an enable, or it appears while it should be masked. A vector that is not cleared at the snapshot shows up as extra bits in the next `vec_wr_data`, one write later. A premature interrupt shows as `irq_single` without a preceding acknowledged request, in the very cycle it happens.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    typedef enum logic [2:0] {
        ST_MASKED,
        ST_IDLE,
        ST_MODERATE,
        ST_WRITE,
        ST_FIRE
    } irq_state_e;
endpackage

// File: rtl/rxirq_mod_timer.sv
module rxirq_mod_timer #(
    parameter int TIMER_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               evt,
    input  logic               clr,
    input  logic [TIMER_W-1:0] delay,
    input  logic [CNT_W-1:0]   thresh,
    output logic               fire
);
    localparam logic [TIMER_W-1:0] TMR_MAX = '1;
    localparam logic [CNT_W-1:0]   CNT_MAX = '1;
    localparam logic [CNT_W-1:0]   CNT_ONE = CNT_W'(1);

    logic               active;
    logic [TIMER_W-1:0] tmr;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tmr    <= '0;
            cnt    <= '0;
        end else if (clr) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            tmr    <= '0;
            cnt    <= CNT_ONE;
        end else if (active) begin
            if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
            if (evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        fire = active && ((tmr >= delay) || ((thresh != '0) && (cnt >= thresh)));
    end

    // R3: a cleared engine cannot expire in the next cycle
    assert_no_fire_after_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !start |=> !fire);
endmodule

// File: rtl/rxirq_single_ctl.sv
module rxirq_single_ctl #(
    parameter int NQ      = 4,
    parameter int TIMER_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_mode,
    input  logic [NQ-1:0]      work,
    input  logic               sw_en,
    input  logic               wr_done,
    input  logic [TIMER_W-1:0] delay,
    input  logic [CNT_W-1:0]   thresh,
    output logic               wr_req,
    output logic [NQ-1:0]      wr_vec,
    output logic               irq,
    output logic               masked
);
    import rxirq_pkg::*;

    irq_state_e    state, nxt;
    logic [NQ-1:0] vec_q, snap_q, work_g;
    logic          sw_en_g, t_start, t_clr, t_fire;

    assign work_g  = active_mode ? work : '0;
    assign sw_en_g = active_mode & sw_en;

    rxirq_mod_timer #(.TIMER_W(TIMER_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .evt(|work_g),
        .clr(t_clr), .delay(delay), .thresh(thresh), .fire(t_fire)
    );

    always_comb begin
        nxt     = state;
        t_start = 1'b0;
        t_clr   = 1'b0;
        unique case (state)
            ST_MASKED: if (sw_en_g) begin
                if ((vec_q != '0) || (work_g != '0)) begin
                    t_start = 1'b1;
                    nxt     = ST_MODERATE;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE: if (work_g != '0) begin
                t_start = 1'b1;
                nxt     = ST_MODERATE;
            end
            ST_MODERATE: if (t_fire) begin
                t_clr = 1'b1;
                nxt   = ST_WRITE;
            end
            ST_WRITE: if (wr_done) nxt = ST_FIRE;
            ST_FIRE:  nxt = ST_MASKED;
            default:  nxt = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_MASKED;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            snap_q <= '0;
        end else if (state == ST_MODERATE && t_fire) begin
            snap_q <= vec_q;
            vec_q  <= work_g;
        end else begin
            vec_q <= vec_q | work_g;
        end
    end

    always_comb begin
        wr_req = (state == ST_WRITE);
        irq    = (state == ST_FIRE);
        masked = (state == ST_MASKED);
        wr_vec = snap_q;
    end

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_done |=> wr_req && $stable(wr_vec));
    assert_irq_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_req && wr_done));
    assert_masked_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> masked && !irq);
    assert_stay_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        masked && !sw_en_g |=> masked && !wr_req);
    assert_vec_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> wr_vec != '0);
endmodule

// File: rtl/rxirq_queue_ctl.sv
module rxirq_queue_ctl #(
    parameter int TIMER_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_mode,
    input  logic               work,
    input  logic               sw_en,
    input  logic [TIMER_W-1:0] delay,
    input  logic [CNT_W-1:0]   thresh,
    output logic               irq,
    output logic               masked
);
    import rxirq_pkg::*;

    irq_state_e state, nxt;
    logic       pend_q, work_g, sw_en_g, t_start, t_clr, t_fire;

    assign work_g  = active_mode & work;
    assign sw_en_g = active_mode & sw_en;

    rxirq_mod_timer #(.TIMER_W(TIMER_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .evt(work_g),
        .clr(t_clr), .delay(delay), .thresh(thresh), .fire(t_fire)
    );

    always_comb begin
        nxt     = state;
        t_start = 1'b0;
        t_clr   = 1'b0;
        unique case (state)
            ST_MASKED: if (sw_en_g) begin
                if (pend_q || work_g) begin
                    t_start = 1'b1;
                    nxt     = ST_MODERATE;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE: if (work_g) begin
                t_start = 1'b1;
                nxt     = ST_MODERATE;
            end
            ST_MODERATE: if (t_fire) begin
                t_clr = 1'b1;
                nxt   = ST_FIRE;
            end
            ST_FIRE: nxt = ST_MASKED;
            default: nxt = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_MASKED;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               pend_q <= 1'b0;
        else if (state == ST_MODERATE && t_fire)  pend_q <= work_g;
        else                                      pend_q <= pend_q | work_g;
    end

    always_comb begin
        irq    = (state == ST_FIRE);
        masked = (state == ST_MASKED);
    end

    assert_q_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq && masked);
    assert_q_stay_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        masked && !sw_en_g |=> masked);
endmodule

// File: rtl/rxq_irq_moderator.sv
module rxq_irq_moderator #(
    parameter int NQ      = 4,
    parameter int TIMER_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_per_q,
    input  logic [TIMER_W-1:0] mod_delay,
    input  logic [CNT_W-1:0]   mod_thresh,
    input  logic [NQ-1:0]      work_in,
    input  logic               sw_en_single,
    input  logic [NQ-1:0]      sw_en_q,
    input  logic               vec_wr_done,
    output logic               vec_wr_req,
    output logic [NQ-1:0]      vec_wr_data,
    output logic               irq_single,
    output logic [NQ-1:0]      irq_q
);
    logic          single_masked;
    logic [NQ-1:0] q_masked;
    logic          all_masked;

    rxirq_single_ctl #(.NQ(NQ), .TIMER_W(TIMER_W), .CNT_W(CNT_W)) u_single (
        .clk(clk), .rst_n(rst_n), .active_mode(!mode_per_q), .work(work_in),
        .sw_en(sw_en_single), .wr_done(vec_wr_done), .delay(mod_delay),
        .thresh(mod_thresh), .wr_req(vec_wr_req), .wr_vec(vec_wr_data),
        .irq(irq_single), .masked(single_masked)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        rxirq_queue_ctl #(.TIMER_W(TIMER_W), .CNT_W(CNT_W)) u_q (
            .clk(clk), .rst_n(rst_n), .active_mode(mode_per_q),
            .work(work_in[g]), .sw_en(sw_en_q[g]), .delay(mod_delay),
            .thresh(mod_thresh), .irq(irq_q[g]), .masked(q_masked[g])
        );
    end

    assign all_masked = single_masked && (&q_masked);

    assert_mode_change_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_per_q) |-> $past(all_masked));
    assert_single_quiet_in_q_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_per_q |-> !vec_wr_req && !irq_single);
    assert_q_quiet_in_single_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_per_q |-> irq_q == '0);
endmodule

// File: tb/tb_rxq_irq_moderator.sv
module tb_rxq_irq_moderator;
    localparam int NQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_per_q = 1'b0;
    logic [15:0]   mod_delay = 16'd5;
    logic [7:0]    mod_thresh = 8'd0;
    logic [NQ-1:0] work_in = '0;
    logic          sw_en_single = 1'b0;
    logic [NQ-1:0] sw_en_q = '0;
    logic          vec_wr_done = 1'b0;
    logic          vec_wr_req;
    logic [NQ-1:0] vec_wr_data;
    logic          irq_single;
    logic [NQ-1:0] irq_q;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    rxq_irq_moderator #(.NQ(NQ), .TIMER_W(16), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .mode_per_q(mode_per_q), .mod_delay(mod_delay),
        .mod_thresh(mod_thresh), .work_in(work_in), .sw_en_single(sw_en_single),
        .sw_en_q(sw_en_q), .vec_wr_done(vec_wr_done), .vec_wr_req(vec_wr_req),
        .vec_wr_data(vec_wr_data), .irq_single(irq_single), .irq_q(irq_q)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit obs(input int sel);
        if (sel < 0) return vec_wr_req;
        return irq_q[sel];
    endfunction

    // Drive work/enables at a negedge; lat counts edges, the sampling edge being 1.
    task automatic stim_wait(input logic [NQ-1:0] wmask, input int whold, input logic sen,
                             input logic [NQ-1:0] qen, input int sel, output int lat);
        @(negedge clk);
        work_in = wmask; sw_en_single = sen; sw_en_q = qen;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat >= whold) work_in = '0;
            sw_en_single = 1'b0; sw_en_q = '0;
        end while (!obs(sel) && lat < 300);
    endtask

    task automatic pulse(input logic [NQ-1:0] wmask, input logic sen, input logic [NQ-1:0] qen);
        @(negedge clk);
        work_in = wmask; sw_en_single = sen; sw_en_q = qen;
        @(negedge clk);
        work_in = '0; sw_en_single = 1'b0; sw_en_q = '0;
    endtask

    task automatic quiet(input int n, output bit r, output bit i, output logic [NQ-1:0] q);
        r = 0; i = 0; q = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            r |= vec_wr_req; i |= irq_single; q |= irq_q;
        end
    endtask

    task automatic ack(input string tag);
        @(negedge clk);
        vec_wr_done = 1'b1;
        @(negedge clk);
        vec_wr_done = 1'b0;
        chk(irq_single == 1'b1, {tag, " R5 irq after done"}, int'(irq_single), 1);
        @(negedge clk);
        chk(irq_single == 1'b0, {tag, " R5 irq one cycle"}, int'(irq_single), 0);
    endtask

    task automatic t_reset();
        bit r, i; logic [NQ-1:0] q;
        repeat (3) @(negedge clk);
        chk(!vec_wr_req && !irq_single && irq_q == '0, "R1 outputs in reset",
            int'({vec_wr_req, irq_single, irq_q}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!vec_wr_req && !irq_single && irq_q == '0, "R1 outputs after reset",
            int'({vec_wr_req, irq_single, irq_q}), 0);
        pulse(4'b0010, 1'b0, '0);
        quiet(12, r, i, q);
        chk(!r && !i, "R1 masked at reset", int'({r, i}), 0);
    endtask

    task automatic t_reenable();
        int lat;
        stim_wait('0, 1, 1'b1, '0, -1, lat);
        chk(lat == 7, "R8 enable with pending latency", lat, 7);
        chk(vec_wr_data == 4'b0010, "R2 vector from masked work", int'(vec_wr_data), 2);
        repeat (3) @(negedge clk);
        chk(vec_wr_req && vec_wr_data == 4'b0010, "R5 request held",
            int'({vec_wr_req, vec_wr_data}), 'h12);
        chk(!irq_single, "R5 no irq before done", int'(irq_single), 0);
        ack("reenable");
    endtask

    task automatic t_masked();
        int lat; bit r, i; logic [NQ-1:0] q;
        pulse(4'b1000, 1'b0, '0);
        quiet(12, r, i, q);
        chk(!r && !i, "R6 masked after irq", int'({r, i}), 0);
        stim_wait('0, 1, 1'b1, '0, -1, lat);
        chk(lat == 7, "R8 restart on enable", lat, 7);
        chk(vec_wr_data == 4'b1000, "R6 masked work kept", int'(vec_wr_data), 8);
        ack("masked");
    endtask

    task automatic t_timer();
        int lat;
        pulse('0, 1'b1, '0);
        stim_wait(4'b0110, 1, 1'b0, '0, -1, lat);
        chk(lat == 7, "R3 timer latency D=5", lat, 7);
        chk(vec_wr_data == 4'b0110, "R2 vector bits", int'(vec_wr_data), 6);
        ack("timer");
    endtask

    task automatic t_count();
        int lat;
        mod_thresh = 8'd3; mod_delay = 16'd20;
        pulse('0, 1'b1, '0);
        stim_wait(4'b0101, 3, 1'b0, '0, -1, lat);
        chk(lat == 4, "R4 count trigger N=3", lat, 4);
        chk(vec_wr_data == 4'b0101, "R4 count vector", int'(vec_wr_data), 5);
        ack("count");
    endtask

    task automatic t_thr0();
        int lat;
        mod_thresh = 8'd0; mod_delay = 16'd5;
        pulse('0, 1'b1, '0);
        stim_wait(4'b0001, 5, 1'b0, '0, -1, lat);
        chk(lat == 7, "R4 threshold 0 disables count", lat, 7);
        ack("thr0");
    endtask

    task automatic t_snapshot();
        int lat;
        pulse('0, 1'b1, '0);
        stim_wait(4'b0001, 1, 1'b0, '0, -1, lat);
        chk(lat == 7, "R7 first request latency", lat, 7);
        pulse(4'b0100, 1'b0, '0);
        chk(vec_wr_data == 4'b0001 && vec_wr_req, "R7 snapshot unchanged",
            int'(vec_wr_data), 1);
        ack("snapshot");
        stim_wait('0, 1, 1'b1, '0, -1, lat);
        chk(lat == 7, "R7 late bits restart", lat, 7);
        chk(vec_wr_data == 4'b0100, "R7 late bits in next write", int'(vec_wr_data), 4);
        ack("snapshot2");
    endtask

    task automatic t_perq();
        int lat; bit r, i; logic [NQ-1:0] q;
        @(negedge clk) mode_per_q = 1'b1;
        pulse('0, 1'b0, 4'b0011);
        stim_wait(4'b0001, 1, 1'b0, '0, 0, lat);
        chk(lat == 7, "R9 queue 0 latency", lat, 7);
        chk(!vec_wr_req && !irq_single && irq_q == 4'b0001, "R9 only irq_q0",
            int'({vec_wr_req, irq_single, irq_q}), 1);
        @(negedge clk);
        chk(irq_q == '0, "R9 irq_q one cycle", int'(irq_q), 0);
        stim_wait(4'b0010, 1, 1'b0, '0, 1, lat);
        chk(lat == 7, "R9 queue 1 latency", lat, 7);
        pulse('0, 1'b0, 4'b0010);
        stim_wait(4'b0011, 1, 1'b0, '0, 1, lat);
        chk(lat == 7, "R10 queue 1 re-enabled alone", lat, 7);
        quiet(12, r, i, q);
        chk(q == '0, "R10 queue 0 stays masked", int'(q), 0);
        stim_wait('0, 1, 1'b0, 4'b0001, 0, lat);
        chk(lat == 7, "R10 pending queue 0 on enable", lat, 7);
    endtask

    task automatic t_mode();
        bit r, i; logic [NQ-1:0] q;
        pulse(4'b0001, 1'b1, '0);
        quiet(12, r, i, q);
        chk(!r && !i, "R11 single enable ignored in per-queue mode", int'({r, i}), 0);
        @(negedge clk) mode_per_q = 1'b0;
        pulse('0, 1'b0, 4'b1111);
        @(negedge clk) mode_per_q = 1'b1;
        pulse(4'b1111, 1'b0, '0);
        quiet(12, r, i, q);
        chk(q == '0, "R11 queue enables ignored in single mode", int'(q), 0);
        @(negedge clk) mode_per_q = 1'b0;
        pulse('0, 1'b1, '0);
        quiet(12, r, i, q);
        chk(!r && !i, "R11 no vector gathered in per-queue mode", int'({r, i}), 0);
    endtask

    initial begin
        t_reset();
        t_reenable();
        t_masked();
        t_timer();
        t_count();
        t_thr0();
        t_snapshot();
        t_perq();
        t_mode();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule